// File: doc/BRIEF.md
# Dual-Speed CPU Clock Arbiter

This block sits between a CPU with a 24-bit address bus and a slow host computer bus. The fast clock runs at eight times the host bus clock, for example about 14.32 MHz against about 1.79 MHz. For every CPU access the block decodes the address and decides whether the access finishes at fast-clock speed or is stretched to a full host-bus cycle. Onboard fast RAM can run fast. Host ROM and memory-mapped I/O always run at host speed.

A new access is signalled by a one-clock `cyc_valid` pulse in an idle cycle. The speed decision is taken during that clock and registered at its end, which stands for the mid-cycle latch point. A fast access then completes in the next clock. A slow access first waits for the next host-phase boundary and then occupies exactly one whole host cycle. The CPU clock enable `cpu_clk_en` is held low until the last clock of that cycle. The host phase counter is free-running from reset.

The speed policy is chosen by parameter. In the register policy, a software turbo bit gates fast operation. That bit sits in a control register decoded in bank $FF, page $80. In the bank policy, bank $00 is slow and all other banks are fast. In both policies the hardware turbo-disable input forces every access slow.

The controller has four states:
- `ST_IDLE`: waiting for an access. It goes to `ST_FAST` on a fast decision, to `ST_HOST` when the current clock is the last one of a host cycle, and otherwise to `ST_ALIGN`.
- `ST_FAST`: the one-clock fast completion. It returns to `ST_IDLE`.
- `ST_ALIGN`: waits for the host boundary. It goes to `ST_HOST` after the last phase clock.
- `ST_HOST`: the whole host cycle. It returns to `ST_IDLE` after its last clock.

Top module: `dual_speed_arbiter`

## Requirements
- R1: After reset, `cpu_clk_en`, `host_cyc` and `host_wr` are low and the turbo bit is 0. With POLICY=0, a read of the control register therefore returns 0 and runs slow.
- R2: With the turbo bit set and POLICY=0, an access outside the host region raises `cpu_clk_en` for exactly one clock, in the clock after the `cyc_valid` clock. It raises no `host_cyc`.
- R3: With POLICY=0, addresses in bank $00 from HOST_BASE (default $C000) to $FFFF form the host region. They always run slow, even with the turbo bit set.
- R4: A slow access holds `host_cyc` high for exactly RATIO (8) consecutive clocks. Those clocks start at host phase 0, where the phase counts clocks since reset modulo RATIO. `cpu_clk_en` is high only in the last of those clocks.
- R5: The control register is selected by any address from $FF8000 to $FF80FF. Addresses $FF8100, $FF7FFF and $008000 do not select it, and writes to them leave the turbo bit unchanged.
- R6: A read of the control register returns the turbo bit on `reg_rdata[0]` in its completion clock, with bits 7..1 at zero. `reg_rdata` is 0 in every other clock.
- R7: While `turbo_off` is 1, every access runs slow, in either policy.
- R8: A write to the control register loads `turbo_wbit` (1 = fast). The new value governs the access that follows the write and never the write itself.
- R9: With POLICY=1, accesses to bank $00 run slow and accesses to all other banks run fast, unless `turbo_off` is 1.
- R10: `host_wr` is high exactly in the `host_cyc` clocks of a slow write access. It stays low for reads.
- R11: `cyc_valid` is ignored while an access is in progress. A register write presented then does not change the turbo bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_valid | input | 1 | One-clock pulse that starts an access |
| cpu_addr | input | 24 | CPU address of the access |
| cpu_rw_n | input | 1 | 1 = read, 0 = write |
| turbo_wbit | input | 1 | Data bit 0 written to the control register |
| turbo_off | input | 1 | Hardware switch; 1 forces every access slow |
| cpu_clk_en | output | 1 | High in the clock in which the CPU access completes |
| host_cyc | output | 1 | High for each clock of a host-bus cycle |
| host_wr | output | 1 | High during a host-bus write cycle |
| reg_rdata | output | 8 | Control register read data in the completion clock |

## Verification
The checks assume that `cyc_valid` pulses only when the block is idle, unless the pulse is meant to be ignored. They also assume the address and write bit stay stable in the pulse clock, and that `turbo_off` changes only between accesses. The stimulus runs one access at a time and then waits twenty clocks, which is longer than the worst slow latency of fifteen clocks. Ignored pulses are injected only in the middle of slow accesses. Idle gaps of zero to eight clocks before accesses sweep every host phase at which a slow access can start.

// File: rtl/dsa_pkg.sv
package dsa_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FAST,
        ST_ALIGN,
        ST_HOST
    } dsa_state_e;

    typedef struct packed {
        logic is_reg;
        logic is_write;
        logic wbit;
    } dsa_access_t;
endpackage

// File: rtl/dsa_phase.sv
module dsa_phase #(
    parameter int RATIO = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic ph_last
);
    localparam int PW = (RATIO > 2) ? $clog2(RATIO) : 1;
    localparam logic [PW-1:0] LAST = PW'(RATIO - 1);

    logic [PW-1:0] ph;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          ph <= '0;
        else if (ph == LAST) ph <= '0;
        else                 ph <= ph + 1'b1;
    end

    assign ph_last = (ph == LAST);
endmodule

// File: rtl/dsa_decode.sv
module dsa_decode #(
    parameter int          POLICY    = 0,
    parameter logic [15:0] HOST_BASE = 16'hC000,
    parameter logic [15:0] REG_PAGE  = 16'hFF80
) (
    input  logic [23:0] addr,
    input  logic        turbo_on,
    input  logic        turbo_off,
    output logic        is_reg,
    output logic        slow
);
    logic bank0;
    logic host_rgn;

    assign is_reg   = (addr[23:8] == REG_PAGE);
    assign bank0    = (addr[23:16] == 8'h00);
    assign host_rgn = bank0 && (addr[15:0] >= HOST_BASE);

    generate
        if (POLICY == 0) begin : g_reg_policy
            assign slow = turbo_off | ~turbo_on | host_rgn;
        end else begin : g_bank_policy
            assign slow = turbo_off | bank0;
        end
    endgenerate
endmodule

// File: rtl/dsa_turbo_reg.sv
module dsa_turbo_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wbit,
    output logic turbo_on
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     turbo_on <= 1'b0;
        else if (wr_en) turbo_on <= wbit;
    end
endmodule

// File: rtl/dual_speed_arbiter.sv
module dual_speed_arbiter #(
    parameter int          RATIO     = 8,
    parameter int          POLICY    = 0,
    parameter logic [15:0] HOST_BASE = 16'hC000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cyc_valid,
    input  logic [23:0] cpu_addr,
    input  logic        cpu_rw_n,
    input  logic        turbo_wbit,
    input  logic        turbo_off,
    output logic        cpu_clk_en,
    output logic        host_cyc,
    output logic        host_wr,
    output logic [7:0]  reg_rdata
);
    import dsa_pkg::*;

    dsa_state_e  state, state_nxt;
    dsa_access_t acc_q;
    logic        ph_last;
    logic        turbo_on;
    logic        dec_reg;
    logic        dec_slow;
    logic        idle_w;
    logic        reg_we;

    dsa_phase #(.RATIO(RATIO)) u_phase (
        .clk(clk), .rst_n(rst_n), .ph_last(ph_last)
    );

    dsa_decode #(.POLICY(POLICY), .HOST_BASE(HOST_BASE)) u_decode (
        .addr(cpu_addr), .turbo_on(turbo_on), .turbo_off(turbo_off),
        .is_reg(dec_reg), .slow(dec_slow)
    );

    dsa_turbo_reg u_turbo (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_we),
        .wbit(acc_q.wbit), .turbo_on(turbo_on)
    );

    assign idle_w = (state == ST_IDLE);

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (cyc_valid) begin
                    if (!dec_slow)    state_nxt = ST_FAST;
                    else if (ph_last) state_nxt = ST_HOST;
                    else              state_nxt = ST_ALIGN;
                end
            end
            ST_FAST:  state_nxt = ST_IDLE;
            ST_ALIGN: if (ph_last) state_nxt = ST_HOST;
            ST_HOST:  if (ph_last) state_nxt = ST_IDLE;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            acc_q <= '0;
        end else begin
            state <= state_nxt;
            if (idle_w && cyc_valid) begin
                acc_q.is_reg   <= dec_reg;
                acc_q.is_write <= ~cpu_rw_n;
                acc_q.wbit     <= turbo_wbit;
            end
        end
    end

    always_comb begin
        cpu_clk_en = 1'b0;
        host_cyc   = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_FAST:  cpu_clk_en = 1'b1;
            ST_ALIGN: ;
            ST_HOST: begin
                host_cyc   = 1'b1;
                cpu_clk_en = ph_last;
            end
            default: ;
        endcase
        host_wr   = host_cyc & acc_q.is_write;
        reg_we    = cpu_clk_en & acc_q.is_reg & acc_q.is_write;
        reg_rdata = (cpu_clk_en && acc_q.is_reg && !acc_q.is_write)
                  ? {7'b0, turbo_on} : 8'h00;
    end
endmodule

// File: rtl/dsa_checker.sv
module dsa_checker #(
    parameter int RATIO = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       idle,
    input logic       cyc_valid,
    input logic       turbo_off,
    input logic       cpu_clk_en,
    input logic       host_cyc,
    input logic       host_wr,
    input logic [6:0] rdata_hi
);
    logic [15:0] hlen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        hlen <= '0;
        else if (host_cyc) hlen <= hlen + 16'd1;
        else               hlen <= '0;
    end

    assert_single_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_clk_en |=> !cpu_clk_en);

    assert_hw_override_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && cyc_valid && turbo_off) |=> !cpu_clk_en);

    assert_host_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cyc && cpu_clk_en) |-> (hlen == 16'(RATIO - 1)));

    assert_host_short_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cyc && !cpu_clk_en) |-> (hlen < 16'(RATIO - 1)));

    assert_host_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cyc && cpu_clk_en) |=> !host_cyc);

    assert_wr_in_host_R10: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr |-> host_cyc);

    assert_rdata_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_hi == 7'd0);
endmodule

bind dual_speed_arbiter dsa_checker #(.RATIO(RATIO)) u_chk (
    .clk(clk), .rst_n(rst_n), .idle(idle_w), .cyc_valid(cyc_valid),
    .turbo_off(turbo_off), .cpu_clk_en(cpu_clk_en), .host_cyc(host_cyc),
    .host_wr(host_wr), .rdata_hi(reg_rdata[7:1])
);

// File: tb/dsa_ref_model.sv
module dsa_ref_model #(
    parameter int RATIO     = 8,
    parameter int POLICY    = 0,
    parameter int HOST_BASE = 'hC000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cyc_valid,
    input  logic [23:0] addr,
    input  logic        rw_n,
    input  logic        wbit,
    input  logic        turbo_off,
    output logic        exp_en,
    output logic        exp_host,
    output logic        exp_wr,
    output logic [7:0]  exp_rdata
);
    int cyc, done, hstart;
    bit slow, isreg, wr, wd, turbo, bank0;

    initial begin
        cyc = 0; done = -1; hstart = 0; slow = 0; isreg = 0; wr = 0; wd = 0; turbo = 0;
        exp_en = 0; exp_host = 0; exp_wr = 0; exp_rdata = 0;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            cyc = 0; done = -1; hstart = 0; slow = 0; isreg = 0; wr = 0; wd = 0; turbo = 0;
        end else begin
            if (cyc == done && isreg && wr) turbo = wd;
            if (cyc > done && cyc_valid) begin
                bank0 = (addr[23:16] == 8'h00);
                isreg = (addr[23:8] == 16'hFF80);
                wr    = !rw_n;
                wd    = wbit;
                if (POLICY == 0)
                    slow = turbo_off || !turbo || (bank0 && int'(addr[15:0]) >= HOST_BASE);
                else
                    slow = turbo_off || bank0;
                if (slow) begin
                    hstart = (cyc / RATIO + 1) * RATIO;
                    done   = hstart + RATIO - 1;
                end else begin
                    done = cyc + 1;
                end
            end
            cyc = cyc + 1;
        end
        exp_en    = rst_n && (cyc == done);
        exp_host  = rst_n && slow && done >= 0 && cyc >= hstart && cyc <= done;
        exp_wr    = exp_host && wr;
        exp_rdata = (exp_en && isreg && !wr) ? {7'b0, turbo} : 8'h00;
    end
endmodule

// File: tb/dual_speed_arbiter_tb_top.sv
module dual_speed_arbiter_tb_top;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        cyc_valid = 1'b0;
    logic [23:0] cpu_addr = '0;
    logic        cpu_rw_n = 1'b1;
    logic        turbo_wbit = 1'b0;
    logic        turbo_off = 1'b0;

    logic       a_en, a_host, a_wr, b_en, b_host, b_wr;
    logic [7:0] a_rd, b_rd;
    logic       ea_en, ea_host, ea_wr, eb_en, eb_host, eb_wr;
    logic [7:0] ea_rd, eb_rd;

    dual_speed_arbiter #(.POLICY(0)) dut_i (
        .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cpu_addr(cpu_addr),
        .cpu_rw_n(cpu_rw_n), .turbo_wbit(turbo_wbit), .turbo_off(turbo_off),
        .cpu_clk_en(a_en), .host_cyc(a_host), .host_wr(a_wr), .reg_rdata(a_rd));

    dual_speed_arbiter #(.POLICY(1)) dut_b_i (
        .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cpu_addr(cpu_addr),
        .cpu_rw_n(cpu_rw_n), .turbo_wbit(turbo_wbit), .turbo_off(turbo_off),
        .cpu_clk_en(b_en), .host_cyc(b_host), .host_wr(b_wr), .reg_rdata(b_rd));

    dsa_ref_model #(.POLICY(0)) ref_a (
        .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .addr(cpu_addr),
        .rw_n(cpu_rw_n), .wbit(turbo_wbit), .turbo_off(turbo_off),
        .exp_en(ea_en), .exp_host(ea_host), .exp_wr(ea_wr), .exp_rdata(ea_rd));

    dsa_ref_model #(.POLICY(1)) ref_b (
        .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .addr(cpu_addr),
        .rw_n(cpu_rw_n), .wbit(turbo_wbit), .turbo_off(turbo_off),
        .exp_en(eb_en), .exp_host(eb_host), .exp_wr(eb_wr), .exp_rdata(eb_rd));

    int    errors = 0;
    int    checks = 0;
    string cur_req = "R1";
    bit    run = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (run) begin
            chk(a_en == ea_en,     cur_req, "cycle A cpu_clk_en", a_en, ea_en);
            chk(a_host == ea_host, cur_req, "cycle A host_cyc",   a_host, ea_host);
            chk(a_wr == ea_wr,     cur_req, "cycle A host_wr",    a_wr, ea_wr);
            chk(a_rd == ea_rd,     cur_req, "cycle A reg_rdata",  a_rd, ea_rd);
            chk(b_en == eb_en,     cur_req, "cycle B cpu_clk_en", b_en, eb_en);
            chk(b_host == eb_host, cur_req, "cycle B host_cyc",   b_host, eb_host);
            chk(b_wr == eb_wr,     cur_req, "cycle B host_wr",    b_wr, eb_wr);
            chk(b_rd == eb_rd,     cur_req, "cycle B reg_rdata",  b_rd, eb_rd);
        end
    end

    int         lat, lat_b;
    logic [7:0] rd;

    task automatic access(input logic [23:0] a, input logic rw, input logic d,
                          input bit poke);
        lat = 0; lat_b = 0; rd = 8'h00;
        cpu_addr = a; cpu_rw_n = rw; turbo_wbit = d; cyc_valid = 1'b1;
        for (int i = 1; i <= 20; i++) begin
            @(negedge clk);
            if (a_en && lat == 0) begin lat = i; rd = a_rd; end
            if (b_en && lat_b == 0) lat_b = i;
            if (i == 1) cyc_valid = 1'b0;
            if (poke && i == 3) begin
                cpu_addr = 24'hFF8000; cpu_rw_n = 1'b0; turbo_wbit = 1'b0; cyc_valid = 1'b1;
            end
            if (poke && i == 4) cyc_valid = 1'b0;
        end
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        run = 1'b1;
        chk(a_en == 1'b0 && a_host == 1'b0 && a_wr == 1'b0, "R1", "reset outputs idle",
            {a_en, a_host, a_wr}, 0);

        cur_req = "R1";
        access(24'hFF8000, 1'b1, 1'b0, 1'b0);
        chk(rd == 8'h00, "R1", "reset turbo readback", rd, 0);
        chk(lat >= 8, "R1", "reset read runs slow", lat, 8);
        chk(lat_b == 1, "R9", "bank policy bank FF fast", lat_b, 1);

        cur_req = "R4";
        access(24'h001000, 1'b1, 1'b0, 1'b0);
        chk(lat >= 8 && lat <= 15, "R4", "slow latency window", lat, 8);

        cur_req = "R8";
        access(24'hFF8000, 1'b0, 1'b1, 1'b0);
        chk(lat >= 8, "R8", "enabling write itself slow", lat, 8);
        cur_req = "R6";
        access(24'hFF8000, 1'b1, 1'b0, 1'b0);
        chk(rd == 8'h01, "R6", "readback after enable", rd, 1);

        cur_req = "R2";
        access(24'h001000, 1'b1, 1'b0, 1'b0);
        chk(lat == 1, "R2", "fast read latency", lat, 1);
        chk(lat_b >= 8, "R9", "bank policy bank 00 slow", lat_b, 8);
        access(24'h123456, 1'b0, 1'b0, 1'b0);
        chk(lat == 1, "R2", "fast write latency", lat, 1);
        chk(lat_b == 1, "R9", "bank policy bank 12 fast", lat_b, 1);

        cur_req = "R3";
        access(24'h00D000, 1'b1, 1'b0, 1'b0);
        chk(lat >= 8, "R3", "host region read slow", lat, 8);
        cur_req = "R10";
        access(24'h00D20A, 1'b0, 1'b0, 1'b0);
        chk(lat >= 8, "R10", "host region write slow", lat, 8);
        access(24'h00BFFF, 1'b1, 1'b0, 1'b0);
        chk(lat == 1, "R3", "just below host base fast", lat, 1);

        cur_req = "R5";
        access(24'hFF80FF, 1'b0, 1'b0, 1'b0);
        access(24'hFF8000, 1'b1, 1'b0, 1'b0);
        chk(rd == 8'h00, "R5", "alias FF80FF write 0", rd, 0);
        access(24'hFF8001, 1'b0, 1'b1, 1'b0);
        access(24'hFF8000, 1'b1, 1'b0, 1'b0);
        chk(rd == 8'h01, "R5", "alias FF8001 write 1", rd, 1);
        access(24'hFF8100, 1'b0, 1'b0, 1'b0);
        access(24'hFF7FFF, 1'b0, 1'b0, 1'b0);
        access(24'h008000, 1'b0, 1'b0, 1'b0);
        access(24'hFF80A5, 1'b1, 1'b0, 1'b0);
        chk(rd == 8'h01, "R5", "non-register writes ignored", rd, 1);

        cur_req = "R8";
        access(24'hFF8000, 1'b0, 1'b0, 1'b0);
        chk(lat == 1, "R8", "disabling write still fast", lat, 1);
        access(24'h002000, 1'b1, 1'b0, 1'b0);
        chk(lat >= 8, "R8", "next access slow after disable", lat, 8);
        access(24'hFF8000, 1'b0, 1'b1, 1'b0);
        access(24'h002000, 1'b1, 1'b0, 1'b0);
        chk(lat == 1, "R8", "next access fast after enable", lat, 1);

        cur_req = "R7";
        turbo_off = 1'b1;
        access(24'h002000, 1'b1, 1'b0, 1'b0);
        chk(lat >= 8, "R7", "override forces slow A", lat, 8);
        access(24'h345678, 1'b1, 1'b0, 1'b0);
        chk(lat_b >= 8, "R7", "override forces slow B", lat_b, 8);
        turbo_off = 1'b0;
        access(24'h002000, 1'b1, 1'b0, 1'b0);
        chk(lat == 1, "R7", "release restores fast", lat, 1);

        cur_req = "R11";
        access(24'h00E000, 1'b1, 1'b0, 1'b1);
        access(24'hFF8000, 1'b1, 1'b0, 1'b0);
        chk(rd == 8'h01, "R11", "write during busy ignored", rd, 1);

        cur_req = "R4";
        for (int k = 0; k <= 8; k++) begin
            repeat (k) @(negedge clk);
            access(24'h004000, 1'b1, 1'b0, 1'b0);
            repeat (k) @(negedge clk);
            access(24'h00E000, (k % 2) == 0, 1'b0, 1'b0);
            chk(lat >= 8 && lat <= 15, "R4", "phase sweep slow latency", lat, 8);
        end

        run = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule